// File: doc/BRIEF.md
# UART Transmit Break and Preamble Sequencer

This block is the character-level control path of an asynchronous serial transmitter. On every bit-rate tick that falls on a character boundary it picks what the line carries next. The choice is one of three character kinds. A data character has a low start bit, the data bits with the least significant first, and high stop bits. An idle preamble is one frame time held high. A break character is a run of low bits followed by one high bit that acts as a stop. The bit clock, parity generation and any buffering live outside the block. A data source offers one word at a time through a valid/ready handshake.

Software-facing controls arrive as plain levels. Turning the transmit enable off and back on queues an idle preamble. A short pulse on the break request produces exactly one break. Holding the break request high produces back-to-back breaks, and each one runs to its full length. Two further inputs set the break length: the frame format and a long-break select.

Top module: `uart_tx_seq`

## Requirements
- R1: During and after reset, with the transmitter disabled, `txd` is 1 and `din_ready` is 0.
- R2: A data character is a 0 start bit, then the data bits with the least significant first, then 1s. The `fmt` input sets the layout: 0 gives 8 data bits and 10 bit times, 1 gives 9 data bits and 11 bit times, and 2 or 3 gives 9 data bits plus one extra 1 for 12 bit times. A following character may start in the very next bit time.
- R3: `din_ready` is high only in a cycle that has `bit_tick` high, the transmitter enabled, the line at a character boundary, and no preamble or break waiting. A word is taken when `din_valid` and `din_ready` are both high.
- R4: `txd` changes only in the cycle after a cycle with `bit_tick` high.
- R5: A rising edge on `tx_en` queues one idle preamble. The preamble is a run of 1s equal in length to a data frame of the current format, and it is sent before any further character.
- R6: A pulse on `brk_req` that ends before its break finishes gives exactly one complete break.
- R7: While `brk_req` stays high, complete breaks follow one another, each separated by exactly one 1 bit time. Releasing the request never shortens the break in progress.
- R8: With `brk_long` at 0, a break is 10, 11 or 12 zero bit times for `fmt` 0, 1 or 2 respectively.
- R9: With `brk_long` at 1, a break is 13 zero bit times for `fmt` 0 and 14 for the other formats. No run of zeros on the line ever exceeds 14 bit times.
- R10: When `tx_en` goes low, a character already in progress completes. After that the line stays at 1 and no word is accepted.
- R11: At a boundary, a waiting preamble goes first, then a waiting break, then data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmitter enable level |
| brk_req | input | 1 | Break request level |
| brk_long | input | 1 | Long-break select |
| fmt | input | 2 | Frame format: 0 = 8 data bits, 1 = 9 data bits, 2/3 = 9 data bits plus extra mark bit |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| din | input | 9 | Data word (bit 8 used only in 9-bit formats) |
| din_valid | input | 1 | Data word offered |
| din_ready | output | 1 | Data word taken this cycle when valid |
| txd | output | 1 | Serial line |

## Verification
The bench records the line once per bit time and measures runs of zeros and ones. From those runs it checks frame layouts, back-to-back framing, and the number and length of breaks for every combination of format and long-break setting. One scenario holds the break request across several breaks and expects exactly one high bit between them; a design that truncated a break on release, or left idle time between breaks, would break the zero-run or gap counts. Other scenarios raise a break or an enable edge while data is waiting and check the order of the characters that follow. A design that let data slip ahead would show a nine-zero run where a break or a run of preamble ones belongs. Disabling the transmitter in the middle of a character checks that the frame still completes and that a word offered later stays unsent.

// File: rtl/uart_seq_pkg.sv
package uart_seq_pkg;

   typedef enum logic [1:0] {
      KIND_NONE = 2'd0,
      KIND_DATA = 2'd1,
      KIND_PRE  = 2'd2,
      KIND_BRK  = 2'd3
   } char_kind_t;

   typedef enum logic [1:0] {
      FMT_8   = 2'd0,
      FMT_9   = 2'd1,
      FMT_9X  = 2'd2,
      FMT_RSV = 2'd3
   } tx_fmt_t;

   function automatic logic fmt_has_extra(input tx_fmt_t f);
      return (f == FMT_9X) || (f == FMT_RSV);
   endfunction

   function automatic logic fmt_is_wide(input tx_fmt_t f);
      return f != FMT_8;
   endfunction

endpackage

// File: rtl/uart_seq_req.sv
module uart_seq_req (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_en,
   input  logic brk_req,
   input  logic take_pre,
   input  logic take_brk,
   output logic pre_want,
   output logic brk_want
);

   logic en_q;
   logic brk_q;
   logic pre_pend;
   logic brk_latch;
   logic en_rise;
   logic brk_rise;

   assign en_rise  = tx_en & ~en_q;
   assign brk_rise = brk_req & ~brk_q;

   // a rising edge counts in its own cycle so data cannot slip ahead of it
   assign pre_want = pre_pend | en_rise;
   // the latch keeps a short pulse alive; the level keeps breaks repeating
   assign brk_want = brk_latch | brk_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         brk_q     <= 1'b0;
         pre_pend  <= 1'b0;
         brk_latch <= 1'b0;
      end else begin
         en_q  <= tx_en;
         brk_q <= brk_req;
         if (take_pre) pre_pend <= 1'b0;
         else          pre_pend <= pre_pend | en_rise;
         if (take_brk) brk_latch <= 1'b0;
         else          brk_latch <= brk_latch | brk_rise;
      end
   end

endmodule

// File: rtl/uart_seq_frame.sv
module uart_seq_frame
   import uart_seq_pkg::*;
#(
   parameter int DATA_W    = 9,
   parameter int BASE_BITS = 8,
   parameter int LONG_ADD  = 3,
   parameter int LONG_MAX  = 14,
   parameter int SR_W      = 15,
   parameter int CNT_W     = 4
) (
   input  char_kind_t         kind,
   input  tx_fmt_t            fmt,
   input  logic               brk_long,
   input  logic [DATA_W-1:0]  data,
   output logic [SR_W-1:0]    pattern,
   output logic [CNT_W-1:0]   nbits
);

   logic [CNT_W-1:0] dbits;
   logic [CNT_W-1:0] flen;
   logic [CNT_W-1:0] blen;
   logic [SR_W-1:0]  data_pat;
   logic [SR_W-1:0]  brk_pat;
   int               long_len;

   always_comb begin
      dbits = fmt_is_wide(fmt) ? CNT_W'(BASE_BITS + 1) : CNT_W'(BASE_BITS);
      flen  = dbits + CNT_W'(2) + (fmt_has_extra(fmt) ? CNT_W'(1) : CNT_W'(0));
      long_len = int'(flen) + LONG_ADD;
      if (!brk_long)
         blen = flen;
      else if (long_len > LONG_MAX)
         blen = CNT_W'(LONG_MAX);
      else
         blen = CNT_W'(long_len);
   end

   for (genvar i = 0; i < SR_W; i++) begin : g_bit
      if (i == 0) begin : g_start
         assign data_pat[i] = 1'b0;
      end else if (i <= DATA_W) begin : g_payload
         assign data_pat[i] = (CNT_W'(i) <= dbits) ? data[i-1] : 1'b1;
      end else begin : g_mark
         assign data_pat[i] = 1'b1;
      end
      assign brk_pat[i] = (CNT_W'(i) >= blen);
   end

   always_comb begin
      case (kind)
         KIND_DATA: begin
            pattern = data_pat;
            nbits   = flen;
         end
         KIND_BRK: begin
            pattern = brk_pat;
            nbits   = blen + CNT_W'(1);
         end
         KIND_PRE: begin
            pattern = '1;
            nbits   = flen;
         end
         default: begin
            pattern = '1;
            nbits   = '0;
         end
      endcase
   end

endmodule

// File: rtl/uart_seq_shift.sv
module uart_seq_shift #(
   parameter int SR_W  = 15,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_tick,
   input  logic             load,
   input  logic [SR_W-1:0]  pattern,
   input  logic [CNT_W-1:0] nbits,
   output logic             boundary,
   output logic             txd
);

   logic             busy;
   logic             last;
   logic [SR_W-1:0]  sr;
   logic [CNT_W-1:0] left;

   assign last     = busy && (left == CNT_W'(1));
   assign boundary = !busy || last;
   assign txd      = busy ? sr[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         sr   <= '1;
         left <= '0;
      end else if (load) begin
         busy <= 1'b1;
         sr   <= pattern;
         left <= nbits;
      end else if (bit_tick && busy) begin
         if (last) begin
            busy <= 1'b0;
            sr   <= '1;
            left <= '0;
         end else begin
            sr   <= {1'b1, sr[SR_W-1:1]};
            left <= left - 1'b1;
         end
      end
   end

endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
   import uart_seq_pkg::*;
#(
   parameter int DATA_W    = 9,
   parameter int BASE_BITS = 8,
   parameter int LONG_ADD  = 3,
   parameter int LONG_MAX  = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              brk_req,
   input  logic              brk_long,
   input  logic [1:0]        fmt,
   input  logic              bit_tick,
   input  logic [DATA_W-1:0] din,
   input  logic              din_valid,
   output logic              din_ready,
   output logic              txd
);

   localparam int SR_W  = LONG_MAX + 1;
   localparam int CNT_W = $clog2(SR_W + 1);

   if (DATA_W != BASE_BITS + 1) begin : g_bad_width
      $error("DATA_W must be one more than BASE_BITS");
   end
   if (LONG_MAX < BASE_BITS + 4) begin : g_bad_cap
      $error("LONG_MAX must hold the longest short break");
   end
   if (LONG_ADD < 1) begin : g_bad_add
      $error("LONG_ADD must lengthen the break");
   end

   logic             pre_want;
   logic             brk_want;
   logic             take_pre;
   logic             take_brk;
   logic             boundary;
   logic             at_edge;
   logic             load;
   char_kind_t       sel;
   logic [SR_W-1:0]  pattern;
   logic [CNT_W-1:0] nbits;

   uart_seq_req u_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .tx_en    (tx_en),
      .brk_req  (brk_req),
      .take_pre (take_pre),
      .take_brk (take_brk),
      .pre_want (pre_want),
      .brk_want (brk_want)
   );

   assign at_edge = bit_tick & boundary & tx_en;

   always_comb begin
      if (pre_want)       sel = KIND_PRE;
      else if (brk_want)  sel = KIND_BRK;
      else if (din_valid) sel = KIND_DATA;
      else                sel = KIND_NONE;
   end

   assign load      = at_edge && (sel != KIND_NONE);
   assign take_pre  = at_edge && (sel == KIND_PRE);
   assign take_brk  = at_edge && (sel == KIND_BRK);
   assign din_ready = at_edge & ~pre_want & ~brk_want;

   uart_seq_frame #(
      .DATA_W    (DATA_W),
      .BASE_BITS (BASE_BITS),
      .LONG_ADD  (LONG_ADD),
      .LONG_MAX  (LONG_MAX),
      .SR_W      (SR_W),
      .CNT_W     (CNT_W)
   ) u_frame (
      .kind     (sel),
      .fmt      (tx_fmt_t'(fmt)),
      .brk_long (brk_long),
      .data     (din),
      .pattern  (pattern),
      .nbits    (nbits)
   );

   uart_seq_shift #(
      .SR_W  (SR_W),
      .CNT_W (CNT_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_tick (bit_tick),
      .load     (load),
      .pattern  (pattern),
      .nbits    (nbits),
      .boundary (boundary),
      .txd      (txd)
   );

endmodule

// File: rtl/uart_tx_seq_chk.sv
module uart_tx_seq_chk #(
   parameter int LONG_MAX = 14
) (
   input logic clk,
   input logic rst_n,
   input logic tx_en,
   input logic brk_req,
   input logic bit_tick,
   input logic din_ready,
   input logic txd
);

   localparam int ZW = $clog2(LONG_MAX + 2) + 1;

   logic [ZW-1:0] zrun;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         zrun <= '0;
      else if (bit_tick) begin
         if (txd)
            zrun <= '0;
         else if (zrun != '1)
            zrun <= zrun + 1'b1;
      end
   end

   // R3
   ready_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      din_ready |-> bit_tick);

   // R10
   ready_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      din_ready |-> tx_en);

   // R4
   line_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_tick |=> $stable(txd));

   // R11
   brk_over_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk_req |-> !din_ready);

   // R5
   pre_over_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_en) |-> !din_ready);

   // R9
   zero_run_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      zrun <= ZW'(LONG_MAX));

endmodule

bind uart_tx_seq uart_tx_seq_chk #(.LONG_MAX(LONG_MAX)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tx_en     (tx_en),
   .brk_req   (brk_req),
   .bit_tick  (bit_tick),
   .din_ready (din_ready),
   .txd       (txd)
);

// File: tb/sim_uart_tx_seq.sv
`timescale 1ns/1ps
module sim_uart_tx_seq;

   localparam int DIV  = 4;
   localparam int HMAX = 4096;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_en = 1'b0;
   logic       brk_req = 1'b0;
   logic       brk_long = 1'b0;
   logic [1:0] fmt = 2'd0;
   logic       bit_tick = 1'b0;
   logic [8:0] din = '0;
   logic       din_valid = 1'b0;
   logic       din_ready;
   logic       txd;

   int nchk = 0;
   int nfail = 0;
   int tick_cnt = 0;
   logic hist [0:HMAX-1];
   int hidx = 0;
   int runlen [0:31];
   int nruns, maxgap, fz;
   int bad_edge = 0;
   int bad_ready = 0;
   logic prev_txd = 1'b1;
   logic prev_tick = 1'b0;

   always #4 clk = ~clk;

   uart_tx_seq u0 (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .brk_req(brk_req),
      .brk_long(brk_long), .fmt(fmt), .bit_tick(bit_tick), .din(din),
      .din_valid(din_valid), .din_ready(din_ready), .txd(txd)
   );

   always @(posedge clk) begin
      tick_cnt <= (tick_cnt == DIV-1) ? 0 : tick_cnt + 1;
      bit_tick <= (tick_cnt == DIV-1);
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (bit_tick) begin
            if (hidx < HMAX) hist[hidx] = txd;
            hidx++;
         end
         if (txd !== prev_txd && !prev_tick) bad_edge++;
         if (din_ready && (!bit_tick || !tx_en)) bad_ready++;
      end
      prev_txd  = txd;
      prev_tick = bit_tick;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_bits(input int n);
      repeat (n*DIV) @(negedge clk);
   endtask

   task automatic align();
      @(negedge clk);
      while (bit_tick) @(negedge clk);
   endtask

   task automatic send_word(input logic [8:0] w);
      din = w;
      din_valid = 1'b1;
      while (!din_ready) @(negedge clk);
      @(negedge clk);
      din_valid = 1'b0;
   endtask

   task automatic pulse_brk();
      brk_req = 1'b1;
      @(negedge clk);
      @(negedge clk);
      brk_req = 1'b0;
   endtask

   task automatic scan(input int s, input int e);
      int cur = 0;
      int gap = 0;
      nruns = 0; maxgap = 0; fz = -1;
      for (int i = s; i < e && i < HMAX; i++) begin
         if (!hist[i]) begin
            if (cur == 0) begin
               if (fz < 0) fz = i;
               if (nruns > 0 && gap > maxgap) maxgap = gap;
            end
            cur++;
         end else begin
            if (cur > 0) begin
               if (nruns < 32) runlen[nruns] = cur;
               nruns++;
               cur = 0;
               gap = 0;
            end
            gap++;
         end
      end
      if (cur > 0) begin
         if (nruns < 32) runlen[nruns] = cur;
         nruns++;
      end
   endtask

   function automatic int flen(input int f);
      return (f == 0) ? 10 : (f == 1) ? 11 : 12;
   endfunction

   function automatic logic exp_bit(input int f, input logic [8:0] w, input int i);
      int nd = (f == 0) ? 8 : 9;
      if (i == 0) return 1'b0;
      if (i <= nd) return w[i-1];
      return 1'b1;
   endfunction

   task automatic enable_clean();
      tx_en = 1'b1;
      wait_bits(16);
   endtask

   // R1
   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(txd === 1'b1, "R1 txd in reset", txd, 1);
      check(din_ready === 1'b0, "R1 ready in reset", din_ready, 0);
      rst_n = 1'b1;
      wait_bits(3);
      check(txd === 1'b1, "R1 txd after reset", txd, 1);
      check(din_ready === 1'b0, "R1 ready after reset", din_ready, 0);
   endtask

   // R5: preamble of 11 ones (fmt 1) precedes the data start bit
   task automatic t_preamble();
      int s;
      fmt = 2'd1;
      align();
      s = hidx;
      tx_en = 1'b1;
      send_word(9'h000);
      wait_bits(20);
      scan(s, hidx);
      check(fz - s == 12, "R5 ones before data", fz - s, 12);
      check(runlen[0] == 10, "R2 fmt1 zero word run", runlen[0], 10);
   endtask

   // R2
   task automatic t_frames();
      logic [8:0] a;
      logic [8:0] b;
      for (int f = 0; f < 3; f++) begin
         int s;
         int n;
         int bad;
         fmt = 2'(f);
         a = (f == 0) ? 9'h0A5 : (f == 1) ? 9'h1A5 : 9'h0F3;
         b = 9'h13C;
         n = flen(f);
         wait_bits(2);
         s = hidx;
         send_word(a);
         send_word(b);
         wait_bits(30);
         scan(s, hidx);
         bad = 0;
         for (int i = 0; i < n; i++) begin
            if (hist[fz+i] !== exp_bit(f, a, i)) bad++;
            if (hist[fz+n+i] !== exp_bit(f, b, i)) bad++;
         end
         check(bad == 0, "R2 frame bits and back-to-back", bad, 0);
      end
   endtask

   // R6 R8 R9
   task automatic t_break_pulse(input logic lng);
      for (int f = 0; f < 3; f++) begin
         int s;
         int want;
         fmt = 2'(f);
         brk_long = lng;
         want = lng ? ((f == 0) ? 13 : 14) : flen(f);
         wait_bits(2);
         s = hidx;
         pulse_brk();
         wait_bits(35);
         scan(s, hidx);
         check(nruns == 1, "R6 single break count", nruns, 1);
         if (lng) check(runlen[0] == want, "R9 long break length", runlen[0], want);
         else     check(runlen[0] == want, "R8 short break length", runlen[0], want);
      end
      brk_long = 1'b0;
   endtask

   // R7
   task automatic t_break_hold();
      int s;
      int bad;
      fmt = 2'd0;
      brk_long = 1'b0;
      wait_bits(2);
      align();
      s = hidx;
      brk_req = 1'b1;
      wait_bits(25);
      brk_req = 1'b0;
      wait_bits(20);
      scan(s, hidx);
      bad = 0;
      for (int i = 0; i < nruns && i < 32; i++) if (runlen[i] != 10) bad++;
      check(nruns == 3, "R7 held break count", nruns, 3);
      check(bad == 0, "R7 each break complete", bad, 0);
      check(maxgap == 1, "R7 one stop bit between breaks", maxgap, 1);
   endtask

   // R11: break queued during a data character wins over the next word
   task automatic t_priority();
      int s;
      fmt = 2'd0;
      wait_bits(2);
      s = hidx;
      send_word(9'h0FF);
      pulse_brk();
      send_word(9'h000);
      wait_bits(30);
      scan(s, hidx);
      check(nruns == 3, "R11 run count", nruns, 3);
      check(runlen[0] == 1, "R11 first word start", runlen[0], 1);
      check(runlen[1] == 10, "R11 break before data", runlen[1], 10);
      check(runlen[2] == 9, "R11 data after break", runlen[2], 9);
   endtask

   // R11 + R5: preamble, then break, then data
   task automatic t_pre_brk_order();
      int s;
      fmt = 2'd0;
      tx_en = 1'b0;
      wait_bits(4);
      align();
      s = hidx;
      tx_en = 1'b1;
      pulse_brk();
      send_word(9'h000);
      wait_bits(20);
      scan(s, hidx);
      check(fz - s == 11, "R11 preamble first", fz - s, 11);
      check(runlen[0] == 10, "R11 break second", runlen[0], 10);
      check(runlen[1] == 9, "R11 data last", runlen[1], 9);
   endtask

   // R10
   task automatic t_disable();
      int s;
      int bad;
      int rdy;
      fmt = 2'd0;
      wait_bits(2);
      s = hidx;
      send_word(9'h055);
      wait_bits(3);
      tx_en = 1'b0;
      din = 9'h000;
      din_valid = 1'b1;
      rdy = 0;
      repeat (20*DIV) begin
         @(negedge clk);
         if (din_ready) rdy++;
      end
      din_valid = 1'b0;
      scan(s, hidx);
      bad = 0;
      for (int i = 0; i < 10; i++) if (hist[fz+i] !== exp_bit(0, 9'h055, i)) bad++;
      check(bad == 0, "R10 frame completes", bad, 0);
      bad = 0;
      for (int i = fz + 10; i < hidx; i++) if (hist[i] !== 1'b1) bad++;
      check(bad == 0, "R10 line idle when disabled", bad, 0);
      check(rdy == 0, "R10 no word taken when disabled", rdy, 0);
      enable_clean();
   endtask

   initial begin
      t_reset();
      t_preamble();
      wait_bits(4);
      t_frames();
      t_break_pulse(1'b0);
      t_break_pulse(1'b1);
      t_break_hold();
      t_priority();
      t_pre_brk_order();
      t_disable();
      // R3 R4
      check(bad_ready == 0, "R3 ready outside tick or while disabled", bad_ready, 0);
      check(bad_edge == 0, "R4 line moved off tick", bad_edge, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule